// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This unit keeps one interrupt-enable register and one interrupt-status register for each locality of a multi-locality command interface. All localities share a single level interrupt line. The transfer engine and the locality arbiter send raise requests. Each request carries a locality number and a mask of event sources. An event is recorded in that locality's status, and the line is driven high, only when the locality has its global enable set and also enables at least one of the requested sources.

Software reaches the registers over a simple register port. The port carries a locality number, a register select, byte-lane enables and write data, and the read data is combinational. Enable and status may be written only by the locality that currently holds the interface. Status bits are cleared by writing ones to them. A hardwired vector register reads back a constant and ignores writes. The polarity field of each enable register is stored but does not change the line.

Top module: `loc_irq_ctrl`

## Requirements
- R1: A raise request whose locality field (3 bits) is 5 or above, that is outside localities 0 to 4, changes no status bit and does not drive the line.
- R2: A raise request for locality L is latched when enable bit 31 of L is set and the request mask shares a bit with L's enable among the source bits 0, 1, 2 and 7 (mask 0x87). The latch ORs the request's source bits (request & 0x87) into L's status, and the line is high from the next clock edge.
- R3: If enable bit 31 of L is clear, or the request shares no source bit with L's enable, the request leaves status and line unchanged.
- R4: A write to enable (select 0) or status (select 2) takes effect only when its locality equals `active_loc`. When `active_loc` is 5 or above, every such write is ignored.
- R5: An enable write leaves the bytes outside the asserted byte enables unchanged. Inside those lanes it stores only the bits of 0x8000_009F (bit 31 as global enable, bits 4:3 as polarity, plus the source bits). All other bits read back as zero.
- R6: A status write clears each bit that is set in both the write data and the source mask, within the enabled lanes. When such a write clears at least one set bit and leaves that locality's status at zero, the line goes low at the next edge.
- R7: After reset every enable register reads 0x0000_0008 (low-level polarity, code 01 in bits 4:3), every status register reads zero, and the line is low.
- R8: Select 1 reads the parameter `VECTOR_NUM` (default 11) for any locality and ignores writes. Select 3 reads zero.
- R9: When a raise and a status clear hit the same locality in one cycle, the new status is (old & ~cleared) | raised, and the line is high afterwards.
- R10: Enable and status of any locality can be read whatever `active_loc` holds. A read of a locality of 5 or above returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_loc | input | 3 | Locality that owns the interface; 5 or above means none |
| raise_vld | input | 1 | Raise request strobe |
| raise_loc | input | 3 | Target locality of the raise request |
| raise_src | input | 32 | Source mask of the request, in status bit positions |
| bus_we | input | 1 | Register write strobe |
| bus_loc | input | 3 | Locality of the register access |
| bus_reg | input | 2 | Register select: 0 enable, 1 vector, 2 status, 3 reserved |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_loc / bus_reg |
| irq_o | output | 1 | Shared level interrupt line |

## Verification
A raise request and a write-one-to-clear status write can land in the same clock cycle. This can happen on the same locality or on two different ones, and in that case the line has to end up high with both effects merged into status. The bench drives both strobes in one cycle: once with the clear aimed at the bit being raised, and once with a drop of another locality's status to zero while a raise is latched. It then judges the outcome by reading back each status register and sampling the line against its own model.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] SRC_MASK  = 32'h0000_0087;
  localparam logic [DW-1:0] EN_WMASK  = 32'h8000_009F;
  localparam logic [DW-1:0] EN_RESET  = 32'h0000_0008;
  localparam int unsigned   GIE_BIT   = 31;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_VECTOR = 2'd1,
    REG_STATUS = 2'd2,
    REG_RSVD   = 2'd3
  } reg_sel_e;

  // expand byte enables into a bit mask
  function automatic logic [DW-1:0] lane_mask(input logic [DW/8-1:0] be);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < DW/8; b++) begin
      if (be[b]) m[8*b +: 8] = 8'hFF;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] merge_enable(input logic [DW-1:0] old,
                                                 input logic [DW-1:0] wdata,
                                                 input logic [DW/8-1:0] be);
    logic [DW-1:0] m;
    m = lane_mask(be);
    return (old & ~m) | (wdata & m & EN_WMASK);
  endfunction

  function automatic logic [DW-1:0] clear_bits(input logic [DW-1:0] wdata,
                                               input logic [DW/8-1:0] be);
    return wdata & lane_mask(be) & SRC_MASK;
  endfunction

  function automatic logic would_latch(input logic [DW-1:0] en,
                                       input logic [DW-1:0] src);
    return en[GIE_BIT] && (|(en & src & SRC_MASK));
  endfunction
endpackage

// File: rtl/loc_irq_decode.sv
module loc_irq_decode
  import loc_irq_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input  logic               raise_vld,
  input  logic [LOC_W-1:0]   raise_loc,
  input  logic               bus_we,
  input  logic [LOC_W-1:0]   bus_loc,
  input  logic [1:0]         bus_reg,
  input  logic [LOC_W-1:0]   active_loc,
  output logic [NUM_LOC-1:0] raise_hit,
  output logic [NUM_LOC-1:0] en_wr_hit,
  output logic [NUM_LOC-1:0] st_wr_hit
);
  logic owner_wr;
  assign owner_wr = bus_we && (bus_loc == active_loc);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_hit
    logic here;
    assign here         = (bus_loc == LOC_W'(i));
    assign raise_hit[i] = raise_vld && (raise_loc == LOC_W'(i));
    assign en_wr_hit[i] = owner_wr && here && (bus_reg == REG_ENABLE);
    assign st_wr_hit[i] = owner_wr && here && (bus_reg == REG_STATUS);
  end
endmodule

// File: rtl/loc_irq_slot.sv
module loc_irq_slot
  import loc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raise_hit,
  input  logic [DW-1:0]   raise_src,
  input  logic            en_wr,
  input  logic            st_wr,
  input  logic [DW/8-1:0] wr_be,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   en_q,
  output logic [DW-1:0]   st_q,
  output logic            latch_ev,
  output logic            drop_ev
);
  logic [DW-1:0] set_bits, clr_bits, st_d;

  assign latch_ev = raise_hit && would_latch(en_q, raise_src);
  assign set_bits = latch_ev ? (raise_src & SRC_MASK) : '0;
  assign clr_bits = st_wr ? clear_bits(wr_data, wr_be) : '0;
  assign st_d     = (st_q & ~clr_bits) | set_bits;
  assign drop_ev  = st_wr && (|(st_q & clr_bits)) && (st_d == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= EN_RESET;
      st_q <= '0;
    end else begin
      st_q <= st_d;
      if (en_wr) en_q <= merge_enable(en_q, wr_data, wr_be);
    end
  end
endmodule

// File: rtl/loc_irq_line.sv
module loc_irq_line #(
  parameter int unsigned NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] latch_vec,
  input  logic [NUM_LOC-1:0] drop_vec,
  output logic               irq_q
);
  // a latch anywhere wins over a drop in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)            irq_q <= 1'b0;
    else if (|latch_vec)   irq_q <= 1'b1;
    else if (|drop_vec)    irq_q <= 1'b0;
  end
endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
  import loc_irq_pkg::*;
#(
  parameter int unsigned NUM_LOC    = 5,
  parameter int unsigned LOC_W      = 3,
  parameter logic [31:0] VECTOR_NUM = 32'd11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] active_loc,
  input  logic             raise_vld,
  input  logic [LOC_W-1:0] raise_loc,
  input  logic [31:0]      raise_src,
  input  logic             bus_we,
  input  logic [LOC_W-1:0] bus_loc,
  input  logic [1:0]       bus_reg,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_o
);
  localparam int unsigned FLAT_W = NUM_LOC * DW;

  logic [NUM_LOC-1:0] raise_hit, en_wr_hit, st_wr_hit;
  logic [NUM_LOC-1:0] latch_vec, drop_vec;
  logic [DW-1:0]      en_q [NUM_LOC];
  logic [DW-1:0]      st_q [NUM_LOC];
  logic [FLAT_W-1:0]  en_flat, st_flat;

  loc_irq_decode #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_dec (
    .raise_vld (raise_vld),
    .raise_loc (raise_loc),
    .bus_we    (bus_we),
    .bus_loc   (bus_loc),
    .bus_reg   (bus_reg),
    .active_loc(active_loc),
    .raise_hit (raise_hit),
    .en_wr_hit (en_wr_hit),
    .st_wr_hit (st_wr_hit)
  );

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    loc_irq_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .raise_hit(raise_hit[i]),
      .raise_src(raise_src),
      .en_wr    (en_wr_hit[i]),
      .st_wr    (st_wr_hit[i]),
      .wr_be    (bus_be),
      .wr_data  (bus_wdata),
      .en_q     (en_q[i]),
      .st_q     (st_q[i]),
      .latch_ev (latch_vec[i]),
      .drop_ev  (drop_vec[i])
    );
    assign en_flat[i*DW +: DW] = en_q[i];
    assign st_flat[i*DW +: DW] = st_q[i];
  end

  loc_irq_line #(.NUM_LOC(NUM_LOC)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_vec(latch_vec),
    .drop_vec (drop_vec),
    .irq_q    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_reg == REG_VECTOR) begin
      bus_rdata = VECTOR_NUM;
    end else begin
      for (int i = 0; i < NUM_LOC; i++) begin
        if (bus_loc == LOC_W'(i)) begin
          if (bus_reg == REG_ENABLE) bus_rdata = en_q[i];
          if (bus_reg == REG_STATUS) bus_rdata = st_q[i];
        end
      end
    end
  end
endmodule

// File: rtl/loc_irq_ctrl_chk.sv
module loc_irq_ctrl_chk
  import loc_irq_pkg::*;
#(
  parameter int unsigned NUM_LOC    = 5,
  parameter int unsigned LOC_W      = 3,
  parameter logic [31:0] VECTOR_NUM = 32'd11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LOC_W-1:0]        active_loc,
  input logic                    raise_vld,
  input logic [LOC_W-1:0]        raise_loc,
  input logic                    bus_we,
  input logic [LOC_W-1:0]        bus_loc,
  input logic [1:0]              bus_reg,
  input logic [31:0]             bus_rdata,
  input logic                    irq_o,
  input logic [NUM_LOC-1:0]      latch_vec,
  input logic [NUM_LOC-1:0]      drop_vec,
  input logic [NUM_LOC*DW-1:0]   en_flat,
  input logic [NUM_LOC*DW-1:0]   st_flat
);
  logic raise_bad;
  assign raise_bad = raise_vld && (int'(raise_loc) >= int'(NUM_LOC));

  AST_BAD_RAISE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    raise_bad |-> (latch_vec == '0)); // R1

  AST_LATCH_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (|latch_vec) |=> irq_o); // R2

  AST_LATCH_ONE_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(latch_vec)); // R1

  AST_FOREIGN_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_loc != active_loc) && !raise_vld) |=>
      ($stable(en_flat) && $stable(st_flat))); // R4

  AST_LINE_FALL_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(|drop_vec)); // R6

  AST_VECTOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reg == REG_VECTOR) |-> (bus_rdata == VECTOR_NUM)); // R8

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_chk
    AST_NO_GIE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_vld && (raise_loc == LOC_W'(i)) && !en_flat[i*DW + GIE_BIT]) |-> !latch_vec[i]); // R3
    AST_EN_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en_flat[i*DW +: DW] & ~EN_WMASK) == '0); // R5
  end
endmodule

bind loc_irq_ctrl loc_irq_ctrl_chk #(
  .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VECTOR_NUM(VECTOR_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .active_loc(active_loc), .raise_vld(raise_vld),
  .raise_loc(raise_loc), .bus_we(bus_we), .bus_loc(bus_loc), .bus_reg(bus_reg),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .latch_vec(latch_vec), .drop_vec(drop_vec),
  .en_flat(en_flat), .st_flat(st_flat)
);

// File: tb/loc_irq_ctrl_test.sv
`timescale 1ns/1ps
module loc_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  active_loc = 3'd7;
  logic        raise_vld = 1'b0;
  logic [2:0]  raise_loc = 3'd0;
  logic [31:0] raise_src = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_loc = 3'd0;
  logic [1:0]  bus_reg = 2'd0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_en [5];
  logic [31:0] m_st [5];
  logic        m_irq;

  always #5 clk = ~clk;

  loc_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .active_loc(active_loc), .raise_vld(raise_vld),
    .raise_loc(raise_loc), .raise_src(raise_src), .bus_we(bus_we), .bus_loc(bus_loc),
    .bus_reg(bus_reg), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  function automatic logic [31:0] src_of(input int k);
    logic [31:0] r;
    r = '0;
    r[0] = k[0]; r[1] = k[1]; r[2] = k[2]; r[7] = k[3];
    return r;
  endfunction

  function automatic logic [31:0] bytes_of(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic expect_eq(input string req, input string what, input logic [31:0] act,
                           input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] l, input logic [1:0] s, output logic [31:0] v);
    bus_loc = l; bus_reg = s; #1; v = bus_rdata;
  endtask

  task automatic chk_loc(input string req, input int l);
    logic [31:0] v;
    rd(3'(l), 2'd0, v); expect_eq(req, $sformatf("enable[%0d]", l), v, m_en[l]);
    rd(3'(l), 2'd2, v); expect_eq(req, $sformatf("status[%0d]", l), v, m_st[l]);
    expect_eq(req, "line", {31'b0, irq_o}, {31'b0, m_irq});
  endtask

  task automatic chk_all(input string req);
    for (int l = 0; l < 5; l++) chk_loc(req, l);
  endtask

  // one clock with optional write and optional raise; model updated from old state
  task automatic step(input logic we, input logic [2:0] wl, input logic [1:0] ws,
                      input logic [3:0] be, input logic [31:0] d,
                      input logic rv, input logic [2:0] rl, input logic [31:0] rs);
    logic [31:0] setm, clrm, old_st;
    bus_we = we; bus_loc = wl; bus_reg = ws; bus_be = be; bus_wdata = d;
    raise_vld = rv; raise_loc = rl; raise_src = rs;
    setm = '0; clrm = '0; old_st = '0;
    if (rv && rl < 5 && m_en[rl][31] && ((m_en[rl] & rs & 32'h87) != 0)) setm = rs & 32'h87;
    if (we && wl == active_loc && wl < 5) begin
      old_st = m_st[wl];
      if (ws == 2'd2) clrm = d & bytes_of(be) & 32'h87;
      if (ws == 2'd0)
        m_en[wl] = (m_en[wl] & ~bytes_of(be)) | (d & bytes_of(be) & 32'h8000_009F);
      m_st[wl] = m_st[wl] & ~clrm;
    end
    if (setm != 0) m_st[rl] = m_st[rl] | setm;
    if (setm != 0) m_irq = 1'b1;
    else if (((old_st & clrm) != 0) && m_st[wl] == 0) m_irq = 1'b0;
    @(posedge clk); #1;
    bus_we = 1'b0; raise_vld = 1'b0;
  endtask

  task automatic wr(input logic [2:0] l, input logic [1:0] s, input logic [3:0] be,
                    input logic [31:0] d);
    step(1'b1, l, s, be, d, 1'b0, 3'd0, 32'h0);
  endtask

  task automatic raise(input logic [2:0] l, input logic [31:0] src);
    step(1'b0, 3'd0, 2'd0, 4'h0, 32'h0, 1'b1, l, src);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int l = 0; l < 5; l++) begin m_en[l] = 32'h8; m_st[l] = 0; end
    m_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7 reset values, R8 vector read, R10 reads without owner
    chk_all("R7");
    for (int l = 0; l < 5; l++) begin
      rd(3'(l), 2'd1, v); expect_eq("R8", "vector", v, 32'd11);
      rd(3'(l), 2'd3, v); expect_eq("R8", "reserved", v, 32'd0);
    end
    rd(3'd6, 2'd0, v); expect_eq("R10", "enable of loc 6", v, 32'd0);

    // R4 no owner: writes ignored
    active_loc = 3'd7;
    wr(3'd0, 2'd0, 4'hF, 32'hFFFF_FFFF);
    chk_all("R4");

    // sweep: every locality, global on/off, every source-enable pattern, every source
    for (int l = 0; l < 5; l++) begin
      active_loc = 3'(l);
      for (int g = 0; g < 2; g++) begin
        for (int m = 0; m < 16; m++) begin
          wr(3'(l), 2'd0, 4'hF, (g ? 32'h8000_0000 : 32'h0) | src_of(m) | 32'h10);
          for (int k = 0; k < 4; k++) begin
            raise(3'(l), src_of(1 << k) | 32'h0000_0F78);
            chk_loc((g == 1 && m[k]) ? "R2" : "R3", l);
            wr(3'(l), 2'd2, 4'hF, 32'hFFFF_FFFF);
            chk_loc("R6", l);
          end
        end
      end
    end

    // R1 invalid localities: all enabled, raise to 5..7
    for (int l = 0; l < 5; l++) begin
      active_loc = 3'(l);
      wr(3'(l), 2'd0, 4'hF, 32'h8000_0087);
    end
    for (int l = 5; l < 8; l++) begin
      raise(3'(l), 32'h87);
      chk_all("R1");
    end

    // R4 foreign writes ignored while loc 2 owns
    active_loc = 3'd2;
    raise(3'd1, 32'h1);
    wr(3'd1, 2'd2, 4'hF, 32'h87);
    wr(3'd3, 2'd0, 4'hF, 32'h0);
    chk_all("R4");

    // R5 byte lanes: clear only top byte, then only low byte
    wr(3'd2, 2'd0, 4'h8, 32'h0000_0000);
    chk_loc("R5", 2);
    wr(3'd2, 2'd0, 4'h1, 32'h0000_0018);
    chk_loc("R5", 2);
    wr(3'd2, 2'd0, 4'hF, 32'hFFFF_FFFF);
    chk_loc("R5", 2);

    // R8 vector write ignored
    wr(3'd2, 2'd1, 4'hF, 32'hDEAD_BEEF);
    rd(3'd2, 2'd1, v); expect_eq("R8", "vector after write", v, 32'd11);
    chk_all("R8");

    // R6 partial clear keeps line; shared line dropped by loc 2 clear
    raise(3'd2, 32'h5);
    wr(3'd2, 2'd2, 4'hF, 32'h1);
    chk_all("R6");
    wr(3'd2, 2'd2, 4'h2, 32'h0000_0004);
    chk_all("R6");
    wr(3'd2, 2'd2, 4'h1, 32'h0000_0004);
    chk_all("R6");
    wr(3'd2, 2'd2, 4'h1, 32'h0000_0078);
    chk_all("R6");

    // R9 same cycle raise and clear on one locality
    raise(3'd2, 32'h80);
    step(1'b1, 3'd2, 2'd2, 4'hF, 32'h80, 1'b1, 3'd2, 32'h81);
    chk_all("R9");
    // R9 drop of loc 2 to zero while loc 0 latches
    step(1'b1, 3'd2, 2'd2, 4'hF, 32'h87, 1'b1, 3'd0, 32'h2);
    chk_all("R9");
    // then clear loc 0 too, dropping the line
    active_loc = 3'd0;
    wr(3'd0, 2'd2, 4'hF, 32'h87);
    chk_all("R6");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule